// File: doc/BRIEF.md
# Masked-CRC Wake-Up Frame Matcher

This block watches the byte stream of received Ethernet frames and raises a one-cycle match pulse when a chosen subset of a frame's leading bytes carries a programmed CRC. A 64-bit byte-select mask picks which of the first 64 bytes of each frame count. Only those bytes are folded into an IEEE 802.3 CRC-32. When the frame ends, the finished CRC is compared with a 32-bit expected value. Bytes the mask does not pick, and every byte past the 64th, are skipped.

Frame bytes arrive one per cycle on `rxByte` while `rxValid` is high. `rxSof` marks the first byte of a frame and `rxEof` marks the last one. A one-byte frame raises both on the same byte. The mask and the expected CRC sit in six 16-bit registers. They are written through a small write port and can be read back combinationally.

Top module: `wakeup_crc_matcher`

## Requirements
- R1: After reset every register reads 0x0000 and `matchPulse` is low.
- R2: Register addresses are as follows. Addresses 0..3 hold mask words 0..3. Address 4 holds bits 15:0 of the expected CRC and address 5 holds bits 31:16. A write takes effect at the clock edge and is visible on `regRdata` from then on. Addresses 6 and 7 read 0x0000 and ignore writes.
- R3: Frame byte n (counting from 1, at most 64) is selected when bit (n-1) mod 16 of mask word (n-1)/16 is 1.
- R4: The CRC follows the Ethernet CRC-32 convention: reflected polynomial 0xEDB88320, preset 0xFFFFFFFF at start of frame, final value inverted. The ASCII bytes "123456789" give 0xCBF43926.
- R5: Unselected bytes do not enter the CRC at all. The result equals the CRC of the selected bytes taken alone, in frame order.
- R6: Bytes after the 64th byte of a frame never change the result.
- R7: A frame shorter than 64 bytes is compared using the CRC of the selected bytes it contained.
- R8: While all 64 mask bits are zero, `matchPulse` never rises.
- R9: `matchPulse` is high for exactly the one cycle after the end-of-frame byte, and only when the CRC equals the expected value.
- R10: A byte with `rxSof` restarts the byte count and the CRC, even inside an unfinished frame.
- R11: Cycles with `rxValid` low are ignored. Valid bytes outside a frame (after an end and before the next start) are also ignored, including any `rxEof` on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Contents of the addressed register (combinational) |
| rxValid | input | 1 | A frame byte is present on `rxByte` |
| rxSof | input | 1 | This byte is the first byte of a frame |
| rxEof | input | 1 | This byte is the last byte of a frame |
| rxByte | input | 8 | Received frame byte |
| matchPulse | output | 1 | One-cycle pulse when the frame's masked CRC matches |

## Verification
A register write shows on `regRdata` in the cycle after its edge, and the bench reads back one cycle after each write. The match result is registered once, so it is due exactly one cycle after the end-of-frame byte is sampled. The bench's behavioural model holds its predicted pulse for that one cycle. Every falling edge compares the model's prediction with `matchPulse`, so an early, late or stretched pulse is caught. Each frame scenario also checks the pulse in the cycle after its last byte, and again one cycle later to confirm the pulse has ended.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int WIN_BYTES  = 64;
  localparam int WORD_BITS  = 16;
  localparam int MASK_WORDS = WIN_BYTES / WORD_BITS;
  localparam int IDX_W      = $clog2(WIN_BYTES);
  localparam int CNT_W      = $clog2(WIN_BYTES + 1);
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic             start;   // start-of-frame byte accepted
    logic             feed;    // a frame byte is accepted this cycle
    logic             finish;  // accepted byte ends the frame
    logic             inWin;   // byte lies within the mask window
    logic [IDX_W-1:0] idx;     // 0-based byte position in frame
  } wakeStrobe_t;
endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  output wakeStrobe_t stb
);
  logic             inFrameQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] curIdx;
  logic             active;

  always_comb begin
    active     = rxValid && (rxSof || inFrameQ);
    curIdx     = rxSof ? '0 : cntQ;
    stb.start  = rxValid && rxSof;
    stb.feed   = active;
    stb.finish = active && rxEof;
    stb.inWin  = (curIdx < CNT_W'(WIN_BYTES));
    stb.idx    = curIdx[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrameQ <= 1'b0;
      cntQ     <= '0;
    end else if (active) begin
      inFrameQ <= !rxEof;
      cntQ     <= (curIdx < CNT_W'(WIN_BYTES)) ? curIdx + 1'b1 : curIdx;
    end
  end

  // counter saturates at the window size (R6)
  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(WIN_BYTES));

  // a start byte that does not end the frame leaves exactly one byte counted (R10)
  assert_restart_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof && !rxEof) |=> (cntQ == CNT_W'(1) && inFrameQ));

  // an ending byte closes the frame (R11)
  assert_frame_closed_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxEof) |=> !inFrameQ);
endmodule

// File: rtl/wake_dpath.sv
module wake_dpath
  import wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic [7:0]  rxByte,
  input  wakeStrobe_t stb,
  output logic        matchPulse
);
  localparam int ADDR_EXP_LO = MASK_WORDS;
  localparam int ADDR_EXP_HI = MASK_WORDS + 1;

  logic [WORD_BITS-1:0] maskWordQ [MASK_WORDS];
  logic [WIN_BYTES-1:0] maskVec;
  logic [15:0]          expLoQ, expHiQ;
  logic [31:0]          crcQ, crcBase, crcNext;
  logic                 take;
  logic                 matchQ;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    return r;
  endfunction

  for (genvar w = 0; w < MASK_WORDS; w++) begin : gMask
    always_ff @(posedge clk) begin
      if (!rstN)
        maskWordQ[w] <= '0;
      else if (regWe && regAddr == 3'(w))
        maskWordQ[w] <= regWdata;
    end
    assign maskVec[w*WORD_BITS +: WORD_BITS] = maskWordQ[w];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expLoQ <= '0;
      expHiQ <= '0;
    end else if (regWe) begin
      if (regAddr == 3'(ADDR_EXP_LO)) expLoQ <= regWdata;
      if (regAddr == 3'(ADDR_EXP_HI)) expHiQ <= regWdata;
    end
  end

  always_comb begin
    regRdata = '0;
    for (int w = 0; w < MASK_WORDS; w++)
      if (regAddr == 3'(w)) regRdata = maskWordQ[w];
    if (regAddr == 3'(ADDR_EXP_LO)) regRdata = expLoQ;
    if (regAddr == 3'(ADDR_EXP_HI)) regRdata = expHiQ;
  end

  always_comb begin
    take    = stb.feed && stb.inWin && maskVec[stb.idx];
    crcBase = stb.start ? 32'hFFFF_FFFF : crcQ;
    crcNext = take ? crcByte(crcBase, rxByte) : crcBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ   <= 32'hFFFF_FFFF;
      matchQ <= 1'b0;
    end else begin
      if (stb.feed) crcQ <= crcNext;
      matchQ <= stb.finish && (|maskVec) && ((~crcNext) == {expHiQ, expLoQ});
    end
  end

  assign matchPulse = matchQ;

  // a pulse only follows an end-of-frame byte (R9)
  assert_pulse_after_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    matchQ |-> $past(stb.finish));

  // no pulse unless the mask had a set bit (R8)
  assert_zero_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    matchQ |-> $past(|maskVec));

  // an unselected start byte leaves the CRC at its preset (R10)
  assert_crc_preset_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.start && !take) |=> (crcQ == 32'hFFFF_FFFF));

  // bytes beyond the window never enter the CRC (R6)
  assert_window_skip_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.feed && !stb.inWin && !stb.start) |=> $stable(crcQ));
endmodule

// File: rtl/wakeup_crc_matcher.sv
module wakeup_crc_matcher
  import wake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        rxValid,
  input  logic        rxSof,
  input  logic        rxEof,
  input  logic [7:0]  rxByte,
  output logic        matchPulse
);
  wakeStrobe_t stb;

  wake_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .stb(stb)
  );

  wake_dpath uDpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rxByte(rxByte), .stb(stb), .matchPulse(matchPulse)
  );
endmodule

// File: tb/tb_wakeup_crc_matcher.sv
module tb_wakeup_crc_matcher;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        rxValid = 1'b0, rxSof = 1'b0, rxEof = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        matchPulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wakeup_crc_matcher dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .rxByte(rxByte), .matchPulse(matchPulse)
  );

  function automatic logic [31:0] refCrc(input logic [7:0] d[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (d[i]) begin
      c ^= {24'h0, d[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] mdlReg [8];
  logic [7:0]  selQ [$];
  int          mdlIdx;
  bit          mdlInFrame;
  bit          expPulse;

  always @(posedge clk) begin
    bit p;
    logic [63:0] m;
    p = 0;
    if (!rstN) begin
      for (int i = 0; i < 8; i++) mdlReg[i] = '0;
      selQ.delete(); mdlIdx = 0; mdlInFrame = 0;
    end else begin
      m = {mdlReg[3], mdlReg[2], mdlReg[1], mdlReg[0]};
      if (rxValid) begin
        if (rxSof) begin selQ.delete(); mdlIdx = 0; mdlInFrame = 1; end
        if (mdlInFrame) begin
          if (mdlIdx < 64 && m[mdlIdx]) selQ.push_back(rxByte);
          mdlIdx++;
          if (rxEof) begin
            p = (m != 0) && (refCrc(selQ) == {mdlReg[5], mdlReg[4]});
            mdlInFrame = 0;
          end
        end
      end
      if (regWe && regAddr < 6) mdlReg[regAddr] = regWdata;
    end
    expPulse <= p;
  end

  always @(negedge clk)
    if (rstN && !done) check(matchPulse == expPulse, "R9 per-cycle", 32'(matchPulse), 32'(expPulse));

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    @(negedge clk);
    rxValid = 0; rxSof = 0; rxEof = 0; regWe = 0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic readCheck(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1 check(regRdata == exp, req, 32'(regRdata), 32'(exp));
  endtask

  task automatic setMask(input logic [63:0] m);
    for (int w = 0; w < 4; w++) writeReg(3'(w), m[w*16 +: 16]);
  endtask

  task automatic setExp(input logic [31:0] e);
    writeReg(3'd4, e[15:0]);
    writeReg(3'd5, e[31:16]);
  endtask

  task automatic driveByte(input bit s, input bit e, input logic [7:0] b);
    @(negedge clk);
    rxValid = 1; rxSof = s; rxEof = e; rxByte = b;
  endtask

  task automatic sendFrame(input logic [7:0] f[$], input bit expMatch, input string req);
    foreach (f[i]) driveByte(i == 0, i == f.size() - 1, f[i]);
    @(negedge clk);
    rxValid = 0; rxSof = 0; rxEof = 0;
    #1 check(matchPulse == expMatch, req, 32'(matchPulse), 32'(expMatch));
    @(negedge clk);
    #1 check(matchPulse == 1'b0, {req, " pulse ends"}, 32'(matchPulse), 32'(0));
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] q[$];
    logic [7:0] sel[$];
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    for (int a = 0; a < 6; a++) readCheck(3'(a), 16'h0000, "R1 reset register");
    check(matchPulse == 0, "R1 reset pulse", 32'(matchPulse), 0);

    // R2 register access
    writeReg(3'd2, 16'hA5C3);
    readCheck(3'd2, 16'hA5C3, "R2 mask word 2");
    writeReg(3'd5, 16'h1234);
    readCheck(3'd5, 16'h1234, "R2 expected high");
    writeReg(3'd6, 16'hFFFF);
    readCheck(3'd6, 16'h0000, "R2 unused address");
    readCheck(3'd2, 16'hA5C3, "R2 word 2 unaffected by address 6");

    // R4 standard check value
    q = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
    setMask(64'h1FF);
    setExp(32'hCBF43926);
    sendFrame(q, 1, "R4 check value match");
    setExp(32'hCBF43927);
    sendFrame(q, 0, "R9 mismatch no pulse");

    // R5 skipped bytes
    q = '{8'h10,8'h21,8'h32,8'h43,8'h54,8'h65};
    sel = '{8'h10,8'h32,8'h54};
    setMask(64'h15);
    setExp(refCrc(sel));
    sendFrame(q, 1, "R5 selected bytes only");
    setExp(refCrc(q));
    sendFrame(q, 0, "R5 unselected bytes excluded");

    // R3 and R6 mapping across words and tail bytes
    q.delete();
    for (int i = 0; i < 80; i++) q.push_back(8'(i * 7 + 3));
    sel = '{q[16], q[63]};
    setMask(64'h8000_0000_0001_0000);
    setExp(refCrc(sel));
    sendFrame(q, 1, "R3 byte 17 and byte 64 mapping");
    for (int i = 64; i < 80; i++) q[i] = ~q[i];
    sendFrame(q, 1, "R6 bytes after 64 ignored");

    // R7 short frame with all-ones mask
    q = '{8'hDE,8'hAD,8'hBE,8'hEF,8'h01,8'h02,8'h03,8'h04,8'h05,8'h06};
    setMask('1);
    setExp(refCrc(q));
    sendFrame(q, 1, "R7 short frame");

    // R8 zero mask: empty-selection CRC is 0, equal to expected 0
    setMask('0);
    setExp(32'h0);
    sendFrame(q, 0, "R8 zero mask");

    // R10 restart mid-frame
    q = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
    setMask(64'h1FF);
    setExp(32'hCBF43926);
    driveByte(1, 0, 8'h55);
    driveByte(0, 0, 8'h66);
    driveByte(0, 0, 8'h77);
    sendFrame(q, 1, "R10 restart on new start");

    // R11 gaps and stray bytes outside a frame
    driveByte(0, 1, 8'h31);
    idle();
    foreach (q[i]) begin
      driveByte(i == 0, i == 8, q[i]);
      if (i != 8) begin
        @(negedge clk);
        rxValid = 0; rxEof = 1; rxByte = 8'hEE; rxSof = 0;
      end
    end
    @(negedge clk);
    rxValid = 0; rxEof = 0;
    #1 check(matchPulse == 1, "R11 gaps ignored", 32'(matchPulse), 1);
    idle();
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule